// File: doc/BRIEF.md
# Flash Protection Mode Controller

This block keeps the protection lifecycle of an on-chip flash and rules on every access made to it. Three requesters share one access point: internal code running through the system-call path, the debug port, and an external programmer. Each presents a valid signal, an operation code and a row number. The block picks one winner per cycle by fixed priority and answers it with a grant or a deny one cycle later. The answer depends on the requester, the current protection mode and the per-row read and write locks.

The mode can only move forward, with one exception. Open may be raised to Protected or to Kill. Protected may fall back to Open, but only once a full flash erase has been confirmed. Kill is final. Any other request leaves the mode unchanged and raises a one-cycle illegal flag. The mode is held in a register with a load port, which stands in for restoring the non-volatile copy at power-up.

Per-row locks are set through a small configuration port. That port works only while the flash is Open. All locks are cleared on the edge where the flash returns from Protected to Open.

Top module: `flashguard_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_o` is 2'b00 (Open), `illegal_req` and `rsp_valid` are 0, all row locks are clear, and `acc_ready` is 0 while no request is valid.
- R2: `mode_o` encodes Open as 2'b00, Protected as 2'b01 and Kill as 2'b10. From Open, a mode request with target 2'b01 moves the flash to Protected on the next edge. A request with target 2'b10 moves it to Kill on the next edge.
- R3: From Protected, a request with target Open succeeds only if `erase_ok` has been seen since Protected was entered, or is high in the same cycle. Without that confirmation, the mode stays Protected and `illegal_req` pulses.
- R4: Kill is terminal. A mode request in Kill pulses `illegal_req` and changes nothing. A load in Kill is ignored. Only reset leaves Kill.
- R5: The unlisted transitions are Open to Open, Protected to Kill, Protected to Protected, and any target of 2'b11. Each one leaves the mode unchanged and sets `illegal_req` high for exactly one cycle.
- R6: `nv_load` writes `nv_mode` into the mode register, except while in Kill. The value 2'b11 is stored as Kill. A load takes priority over a mode request in the same cycle, and that request has no effect and raises no flag. A load does not alter the row locks.
- R7: Source 0 (internal code) is granted read (op 2'b00), write (2'b01) and erase (2'b10) in every mode, whatever the row locks. Op 2'b11 is denied for every source.
- R8: Source 1 (debug port) is denied every operation in Protected and in Kill.
- R9: Source 2 (external programmer) is granted only erase in Protected, whatever the row locks. In Kill it is denied every operation.
- R10: In Open, sources 1 and 2 are denied a read of a row whose read lock is set. They are denied a write or erase of a row whose write lock is set. Otherwise they are granted.
- R11: A configuration write sets both lock bits of one row. It takes effect only while the mode is Open and is ignored otherwise.
- R12: On the edge where the mode returns from Protected to Open through a request, every row's read and write lock is cleared.
- R13: Among valid requesters, source 0 wins over source 2, and source 2 wins over source 1. `acc_ready` is high for the winner only. `rsp_valid`, `rsp_src` and `rsp_grant` appear one cycle after acceptance, and `rsp_src` names the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_valid | input | 1 | Mode change request strobe |
| mreq_target | input | 2 | Requested mode |
| erase_ok | input | 1 | Full flash erase confirmed |
| nv_load | input | 1 | Load the mode register from `nv_mode` |
| nv_mode | input | 2 | Mode value restored from non-volatile storage |
| cfg_valid | input | 1 | Row lock configuration write |
| cfg_row | input | ROW_W | Row addressed by the configuration write |
| cfg_rd_lock | input | 1 | New read lock for that row |
| cfg_wr_lock | input | 1 | New write lock for that row |
| acc_valid | input | 3 | Access request per source (0 internal, 1 debug, 2 programmer) |
| acc_op | input | 6 | Operation per source, source s at bits [2s+1:2s] |
| acc_row | input | 3*ROW_W | Row per source, source s at bits [s*ROW_W +: ROW_W] |
| acc_ready | output | 3 | Request accepted this cycle, one-hot or zero |
| rsp_valid | output | 1 | Registered response present |
| rsp_src | output | 2 | Source the response belongs to |
| rsp_grant | output | 1 | 1 grant, 0 deny |
| mode_o | output | 2 | Current protection mode |
| illegal_req | output | 1 | One-cycle pulse on a rejected mode request |

## Verification
A wrong mode register shows on `mode_o` at the first negative edge after the request. It also shows one cycle later in a debug or programmer response that takes the wrong side. A lost or premature erase confirmation shows as a Protected-to-Open move that either fails or happens too early. A row lock that is missed, or that survives the return to Open, shows only when a later debug or programmer access hits that row. The bench therefore follows each mode step with accesses to locked and unlocked rows. A wrong arbitration choice appears at once on `acc_ready`, before the response register.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN = 2'b00,
    MODE_PROT = 2'b01,
    MODE_KILL = 2'b10
  } fg_mode_e;

  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_WR   = 2'b01,
    OP_ER   = 2'b10,
    OP_NONE = 2'b11
  } fg_op_e;

  localparam int SRC_N = 3;
  localparam logic [1:0] SRC_CPU = 2'd0;
  localparam logic [1:0] SRC_DBG = 2'd1;
  localparam logic [1:0] SRC_PGM = 2'd2;

  // fail-secure: the unused code collapses onto the terminal mode
  function automatic fg_mode_e fg_norm(input logic [1:0] v);
    return (v == 2'b11) ? MODE_KILL : fg_mode_e'(v);
  endfunction
endpackage

// File: rtl/fg_mode_fsm.sv
module fg_mode_fsm
  import fg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mreq_valid,
  input  logic [1:0] mreq_target,
  input  logic       erase_ok,
  input  logic       nv_load,
  input  logic [1:0] nv_mode,
  output fg_mode_e   mode_q,
  output logic       illegal_q,
  output logic       rows_clear
);
  fg_mode_e mode_d;
  logic     erase_seen_q, erase_seen_d;
  logic     bad_d;

  always_comb begin
    mode_d       = mode_q;
    erase_seen_d = erase_seen_q;
    bad_d        = 1'b0;
    rows_clear   = 1'b0;
    if (mode_q == MODE_PROT && erase_ok) erase_seen_d = 1'b1;
    if (nv_load && mode_q != MODE_KILL) begin
      mode_d       = fg_norm(nv_mode);
      erase_seen_d = 1'b0;
    end else if (mreq_valid) begin
      case (mode_q)
        MODE_OPEN: begin
          if (mreq_target == MODE_PROT) begin
            mode_d       = MODE_PROT;
            erase_seen_d = 1'b0;
          end else if (mreq_target == MODE_KILL) begin
            mode_d = MODE_KILL;
          end else begin
            bad_d = 1'b1;
          end
        end
        MODE_PROT: begin
          if (mreq_target == MODE_OPEN && (erase_seen_q || erase_ok)) begin
            mode_d       = MODE_OPEN;
            erase_seen_d = 1'b0;
            rows_clear   = 1'b1;
          end else begin
            bad_d = 1'b1;
          end
        end
        default: bad_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_OPEN;
      erase_seen_q <= 1'b0;
      illegal_q    <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      erase_seen_q <= erase_seen_d;
      illegal_q    <= bad_d;
    end
  end

  // R4
  kill_terminal_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_KILL |=> mode_q == MODE_KILL);
  // R2
  mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b11);
  // R3
  unlock_needs_erase_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PROT && !nv_load && !erase_seen_q && !erase_ok)
      |=> mode_q != MODE_OPEN);
  // R5
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> $past(mreq_valid));
endmodule

// File: rtl/fg_row_prot.sv
module fg_row_prot
  import fg_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ROW_W-1:0]             wr_row,
  input  logic                         wr_rd,
  input  logic                         wr_wr,
  input  logic                         clr_all,
  input  logic [SRC_N-1:0][ROW_W-1:0]  look_row,
  output logic [SRC_N-1:0]             rd_lock,
  output logic [SRC_N-1:0]             wr_lock
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DEPTH-1:0] rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      rd_q <= '0;
      wr_q <= '0;
    end else if (wr_en) begin
      rd_q[wr_row] <= wr_rd;
      wr_q[wr_row] <= wr_wr;
    end
  end

  for (genvar s = 0; s < SRC_N; s++) begin : g_look
    assign rd_lock[s] = rd_q[look_row[s]];
    assign wr_lock[s] = wr_q[look_row[s]];
  end

  // R12
  rows_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (rd_q == '0 && wr_q == '0));
  // R11
  locks_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !clr_all) |=> ($stable(rd_q) && $stable(wr_q)));
endmodule

// File: rtl/fg_access_arb.sv
module fg_access_arb
  import fg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  fg_mode_e         mode,
  input  logic [SRC_N-1:0] acc_valid,
  input  logic [2*SRC_N-1:0] acc_op,
  input  logic [SRC_N-1:0] rd_lock,
  input  logic [SRC_N-1:0] wr_lock,
  output logic [SRC_N-1:0] acc_ready,
  output logic             rsp_valid,
  output logic [1:0]       rsp_src,
  output logic             rsp_grant
);
  logic [SRC_N-1:0] verdict;
  logic [1:0]       win;
  logic             any;

  function automatic logic decide(input logic [1:0] src, input fg_op_e op,
                                  input fg_mode_e md, input logic rl,
                                  input logic wl);
    logic row_ok;
    row_ok = (op == OP_RD) ? !rl : !wl;
    if (op == OP_NONE)     return 1'b0;
    if (src == SRC_CPU)    return 1'b1;
    if (md == MODE_OPEN)   return row_ok;
    if (src == SRC_PGM && md == MODE_PROT) return op == OP_ER;
    return 1'b0;
  endfunction

  for (genvar s = 0; s < SRC_N; s++) begin : g_verdict
    assign verdict[s] = decide(2'(s), fg_op_e'(acc_op[2*s +: 2]), mode,
                               rd_lock[s], wr_lock[s]);
  end

  always_comb begin
    any = 1'b1;
    win = SRC_CPU;
    if (acc_valid[SRC_CPU])      win = SRC_CPU;
    else if (acc_valid[SRC_PGM]) win = SRC_PGM;
    else if (acc_valid[SRC_DBG]) win = SRC_DBG;
    else                         any = 1'b0;
    acc_ready      = '0;
    acc_ready[win] = any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_src   <= '0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_valid <= any;
      rsp_src   <= win;
      rsp_grant <= any && verdict[win];
    end
  end

  // R13
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc_ready));
  // R13
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (|(acc_valid & acc_ready)) |=> rsp_valid);
  // R7
  cpu_always_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ready[SRC_CPU] && acc_op[1:0] != OP_NONE) |=> rsp_grant);
  // R8
  dbg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ready[SRC_DBG] && mode != MODE_OPEN) |=> !rsp_grant);
  // R9
  kill_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_KILL && !acc_ready[SRC_CPU]) |=> !rsp_grant);
endmodule

// File: rtl/flashguard_ctrl.sv
module flashguard_ctrl
  import fg_pkg::*;
#(
  parameter int ROWS  = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mreq_valid,
  input  logic [1:0]         mreq_target,
  input  logic               erase_ok,
  input  logic               nv_load,
  input  logic [1:0]         nv_mode,
  input  logic               cfg_valid,
  input  logic [ROW_W-1:0]   cfg_row,
  input  logic               cfg_rd_lock,
  input  logic               cfg_wr_lock,
  input  logic [2:0]         acc_valid,
  input  logic [5:0]         acc_op,
  input  logic [3*ROW_W-1:0] acc_row,
  output logic [2:0]         acc_ready,
  output logic               rsp_valid,
  output logic [1:0]         rsp_src,
  output logic               rsp_grant,
  output logic [1:0]         mode_o,
  output logic               illegal_req
);
  fg_mode_e                    mode_q;
  logic                        rows_clear;
  logic                        cfg_en;
  logic [SRC_N-1:0][ROW_W-1:0] look_row;
  logic [SRC_N-1:0]            rd_lock, wr_lock;

  for (genvar s = 0; s < SRC_N; s++) begin : g_rowsplit
    assign look_row[s] = acc_row[s*ROW_W +: ROW_W];
  end

  assign cfg_en = cfg_valid && (mode_q == MODE_OPEN);
  assign mode_o = mode_q;

  fg_mode_fsm i_mode (
    .clk, .rst, .mreq_valid, .mreq_target, .erase_ok, .nv_load, .nv_mode,
    .mode_q, .illegal_q(illegal_req), .rows_clear
  );

  fg_row_prot #(.ROWS(ROWS), .ROW_W(ROW_W)) i_rows (
    .clk, .rst, .wr_en(cfg_en), .wr_row(cfg_row), .wr_rd(cfg_rd_lock),
    .wr_wr(cfg_wr_lock), .clr_all(rows_clear), .look_row, .rd_lock, .wr_lock
  );

  fg_access_arb i_arb (
    .clk, .rst, .mode(mode_q), .acc_valid, .acc_op, .rd_lock, .wr_lock,
    .acc_ready, .rsp_valid, .rsp_src, .rsp_grant
  );
endmodule

// File: tb/test_flashguard_ctrl.sv
module test_flashguard_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mreq_valid = 0, erase_ok = 0, nv_load = 0, cfg_valid = 0;
  logic [1:0]  mreq_target = 0, nv_mode = 0;
  logic [3:0]  cfg_row = 0;
  logic        cfg_rd_lock = 0, cfg_wr_lock = 0;
  logic [2:0]  acc_valid = 0;
  logic [5:0]  acc_op = 0;
  logic [11:0] acc_row = 0;
  logic [2:0]  acc_ready;
  logic        rsp_valid, rsp_grant, illegal_req;
  logic [1:0]  rsp_src, mode_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  flashguard_ctrl #(.ROWS(16)) i_flashguard_ctrl (.*);

  // {src[8:7], op[6:5], row[4:1], expected grant[0]} in Open with row 3 read
  // locked, row 5 write locked, row 7 both locked
  localparam logic [8:0] VEC [12] = '{
    {2'd0, 2'd0, 4'd7, 1'b1}, {2'd0, 2'd1, 4'd5, 1'b1},
    {2'd0, 2'd2, 4'd7, 1'b1}, {2'd0, 2'd3, 4'd0, 1'b0},
    {2'd1, 2'd0, 4'd3, 1'b0}, {2'd1, 2'd1, 4'd3, 1'b1},
    {2'd1, 2'd0, 4'd5, 1'b1}, {2'd1, 2'd1, 4'd5, 1'b0},
    {2'd1, 2'd2, 4'd5, 1'b0}, {2'd2, 2'd0, 4'd0, 1'b1},
    {2'd2, 2'd2, 4'd7, 1'b0}, {2'd2, 2'd1, 4'd2, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(input int src, input int op, input int row, input bit exp,
                        input string tag);
    @(negedge clk);
    acc_valid = 0;
    acc_valid[src] = 1'b1;
    acc_op[src*2 +: 2] = 2'(op);
    acc_row[src*4 +: 4] = 4'(row);
    #1 chk(acc_ready == 3'(1 << src), {tag, " ready"}, acc_ready, 1 << src);
    @(negedge clk);
    acc_valid = 0;
    chk(rsp_valid && rsp_src == 2'(src) && rsp_grant == exp, tag,
        {rsp_valid, rsp_src, rsp_grant}, {1'b1, 2'(src), exp});
  endtask

  task automatic mode_req(input int tgt, input bit ers, input int exp_mode,
                          input bit exp_bad, input string tag);
    @(negedge clk);
    mreq_valid = 1; mreq_target = 2'(tgt); erase_ok = ers;
    @(negedge clk);
    mreq_valid = 0; erase_ok = 0;
    chk(mode_o == 2'(exp_mode) && illegal_req == exp_bad, tag,
        {mode_o, illegal_req}, {2'(exp_mode), exp_bad});
  endtask

  task automatic load(input int v, input int exp_mode, input string tag);
    @(negedge clk);
    nv_load = 1; nv_mode = 2'(v);
    @(negedge clk);
    nv_load = 0;
    chk(mode_o == 2'(exp_mode), tag, mode_o, exp_mode);
  endtask

  task automatic cfg(input int row, input bit rd, input bit wr);
    @(negedge clk);
    cfg_valid = 1; cfg_row = 4'(row); cfg_rd_lock = rd; cfg_wr_lock = wr;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(mode_o == 2'b00 && !illegal_req && !rsp_valid && acc_ready == 0,
        "R1 reset", {mode_o, illegal_req, rsp_valid, acc_ready}, 0);

    cfg(3, 1, 0); cfg(5, 0, 1); cfg(7, 1, 1);
    foreach (VEC[i])   // R7 R10 in Open
      access(int'(VEC[i][8:7]), int'(VEC[i][6:5]), int'(VEC[i][4:1]), VEC[i][0],
             "R7/R10 open vector");

    // R13 arbitration
    @(negedge clk);
    acc_valid = 3'b111; acc_op = 0; acc_row = 0;
    #1 chk(acc_ready == 3'b001, "R13 all valid", acc_ready, 1);
    @(negedge clk);
    acc_valid = 3'b110;
    chk(rsp_valid && rsp_src == 0, "R13 rsp src cpu", rsp_src, 0);
    #1 chk(acc_ready == 3'b100, "R13 pgm over dbg", acc_ready, 4);
    @(negedge clk);
    acc_valid = 0;
    chk(rsp_valid && rsp_src == 2, "R13 rsp src pgm", rsp_src, 2);
    @(negedge clk);
    chk(!rsp_valid, "R13 no rsp when idle", rsp_valid, 0);

    mode_req(0, 0, 0, 1, "R5 open to open");
    @(negedge clk);
    chk(!illegal_req, "R5 pulse one cycle", illegal_req, 0);
    mode_req(1, 0, 1, 0, "R2 open to protected");
    access(1, 0, 0, 0, "R8 dbg read protected");
    access(1, 2, 0, 0, "R8 dbg erase protected");
    access(2, 0, 0, 0, "R9 pgm read protected");
    access(2, 2, 7, 1, "R9 pgm erase protected");
    access(0, 1, 5, 1, "R7 cpu write protected");

    cfg(0, 1, 1);                      // ignored outside Open
    load(0, 0, "R6 load open");
    access(1, 0, 0, 1, "R11 cfg ignored in protected");
    access(1, 0, 3, 0, "R6 load keeps row locks");
    load(1, 1, "R6 load protected");

    mode_req(2, 0, 1, 1, "R5 protected to kill");
    mode_req(0, 0, 1, 1, "R3 unlock without erase");
    @(negedge clk); erase_ok = 1;
    @(negedge clk); erase_ok = 0;
    chk(mode_o == 2'b01, "R3 erase alone keeps mode", mode_o, 1);
    mode_req(0, 0, 0, 0, "R3 unlock after erase");
    access(1, 0, 3, 1, "R12 read lock cleared");
    access(1, 1, 5, 1, "R12 write lock cleared");

    mode_req(1, 0, 1, 0, "R2 open to protected again");
    mode_req(0, 1, 0, 0, "R3 unlock with erase same cycle");
    cfg(3, 1, 0);
    access(1, 0, 3, 0, "R11 cfg accepted in open");

    // R6 load beats request
    @(negedge clk);
    nv_load = 1; nv_mode = 2'b01; mreq_valid = 1; mreq_target = 2'b10;
    @(negedge clk);
    nv_load = 0; mreq_valid = 0;
    chk(mode_o == 2'b01 && !illegal_req, "R6 load priority",
        {mode_o, illegal_req}, 2);
    load(0, 0, "R6 load back open");
    load(3, 2, "R6 code 3 is kill");

    mode_req(0, 0, 2, 1, "R4 kill request open");
    load(0, 2, "R4 kill ignores load");
    mode_req(1, 1, 2, 1, "R4 kill with erase");
    access(2, 2, 0, 0, "R9 pgm erase kill");
    access(1, 0, 0, 0, "R8 dbg read kill");
    access(0, 0, 3, 1, "R7 cpu read kill");
    access(0, 3, 0, 0, "R7 op none denied");

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(mode_o == 2'b00, "R1 reset leaves kill", mode_o, 0);
    mode_req(2, 0, 2, 0, "R2 open to kill");

    summary();
    $finish;
  end
endmodule